// File: doc/BRIEF.md
# Reference-Counted Register Reclaimer

This block decides when each physical register of an out-of-order core can be put back on the free list. For every physical register it holds a small reference count and a "renamed" bit. The count goes up when an instruction leaves rename with that register as a source, and down when the instruction issues and reads it. A whole checkpoint of the current mapping adds or removes one reference on every register it names. The checkpoint arrives as a bit vector. The renamed bit is set when a logical register moves its mapping away from the physical register. A register is reclaimed once it is renamed and no longer counted. It does not wait for the redefining instruction to retire.

The block also holds the free list as a one-bit-per-register vector and hands out registers to rename. It always grants the lowest-numbered free register. Before a rename that would push a count past its ceiling can happen, the block stalls that rename. The map table and the register file sit outside this block.

Top module: `reg_reclaimer`

## Requirements
- R1: After reset, physical registers 0 to NUM_ARCH-1 are held (free_mask bit 0), all others are free (bit 1), every count is zero, every renamed bit is clear and ren_stall is low.
- R2: An accepted rename raises the count of each register named on a valid rename source port by one. A valid issue port lowers the count of its register by one. A renamed register is freed only once both kinds of update have brought its count to zero.
- R3: A checkpoint creation (ckpt_new_valid) adds one to the count of every register whose bit is set in ckpt_new_mask. A checkpoint release (ckpt_drop_valid) subtracts one from every register set in ckpt_drop_mask.
- R4: ovw_valid sets the renamed bit of register ovw_tag. A register that is renamed and has count zero after a clock edge shows as 1 in free_mask right after that edge.
- R5: All increments and decrements that reach one register in the same cycle are summed into one net update. Examples: both sources on the same register add two; a rename and an issue on the same register cancel.
- R6: ren_stall is high in any cycle where ren_valid is high and some register's count plus its rename-source hits would exceed 15 (4-bit count). While ren_stall is high, neither the rename increments nor the ovw_valid update take effect.
- R7: When alloc_req is high and any free_mask bit is 1, alloc_gnt is high in the same cycle and alloc_tag is the lowest-numbered free register. That register reads 0 in free_mask after the edge, with its renamed bit cleared. With no free register, alloc_gnt stays low.
- R8: A register that becomes free at a clock edge cannot be granted in the cycle before that edge. The grant in that cycle goes to the lowest register that was already free.
- R9: A register that is renamed but still counted, or that has count zero but is not renamed, stays off the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is leaving rename this cycle |
| ren_src_vld | input | RN_SRCS | Valid flag per rename source port |
| ren_src_tag | input | RN_SRCS*PW | Physical source register per port, port 0 in the low bits |
| ren_stall | output | 1 | Rename refused this cycle to avoid count overflow |
| ovw_valid | input | 1 | Renaming instruction overwrites a mapping |
| ovw_tag | input | PW | Physical register losing its mapping |
| iss_vld | input | ISS_PORTS | Valid flag per issue read port |
| iss_tag | input | ISS_PORTS*PW | Physical register read per issue port |
| ckpt_new_valid | input | 1 | A checkpoint is created |
| ckpt_new_mask | input | NUM_PREGS | Registers active in the new checkpoint's mapping |
| ckpt_drop_valid | input | 1 | A checkpoint is released |
| ckpt_drop_mask | input | NUM_PREGS | Registers active in the released checkpoint's mapping |
| alloc_req | input | 1 | Request for a free register |
| alloc_gnt | output | 1 | A free register is granted |
| alloc_tag | output | PW | Granted register number |
| free_mask | output | NUM_PREGS | Free-list vector, 1 = free |

## Verification
Two functions can land in the same cycle: releasing a register and granting one. The bench sets up a register below the current lowest free one with a single reference left and the renamed bit set. It then issues the last read in the same cycle as an allocation request. It expects the grant to go to the older free register and the released one to be granted on the following request. The other collision is several count updates on one register in one cycle: rename plus issue, or rename plus checkpoint creation. These are judged by the cycle in which the register finally shows up as free.

// File: rtl/rr_pkg.sv
package rr_pkg;
   localparam int unsigned RR_CNT_W      = 4;
   localparam int unsigned RR_NUM_PREGS  = 32;
   localparam int unsigned RR_NUM_ARCH   = 16;
   localparam int unsigned RR_PORTS_DEF  = 2;
endpackage

// File: rtl/rr_hit_count.sv
module rr_hit_count #(
   parameter int unsigned PW    = 5,
   parameter int unsigned N     = 2,
   parameter int unsigned IDX   = 0,
   parameter int unsigned OUT_W = 2
) (
   input  logic [N-1:0]    vld,
   input  logic [N*PW-1:0] tags,
   output logic [OUT_W-1:0] hits
);
   localparam logic [PW-1:0] MY_TAG = PW'(IDX);

   if (OUT_W < $clog2(N + 1)) begin : g_bad_width
      $error("rr_hit_count: OUT_W too narrow");
   end

   always_comb begin
      hits = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (vld[i] && (tags[i*PW +: PW] == MY_TAG)) hits = hits + OUT_W'(1);
      end
   end
endmodule

// File: rtl/rr_lowest_pick.sv
module rr_lowest_pick #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      onehot = '0;
      idx    = '0;
      any    = |req;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IW'(i);
         end
      end
   end

   a_r7_pick_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(onehot));
   a_r7_pick_is_req : assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[idx]);
endmodule

// File: rtl/rr_preg_slot.sv
module rr_preg_slot #(
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned RH_W       = 2,
   parameter int unsigned IH_W       = 2,
   parameter bit          RESET_FREE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RH_W-1:0] ren_hits,
   input  logic            ren_go,
   input  logic            ckpt_inc,
   input  logic [IH_W-1:0] iss_hits,
   input  logic            ckpt_dec,
   input  logic            set_renamed,
   input  logic            grant,
   output logic            ovf_risk,
   output logic            free_q
);
   localparam int unsigned SUM_W = CNT_W + ((RH_W > IH_W) ? RH_W : IH_W) + 1;
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             ren_q, ren_n, free_n;
   logic [SUM_W-1:0] up, down, nxt;

   always_comb begin
      up   = (ren_go ? SUM_W'(ren_hits) : '0) + SUM_W'(ckpt_inc);
      down = SUM_W'(iss_hits) + SUM_W'(ckpt_dec);
      nxt  = SUM_W'(cnt_q) + up - down;
      cnt_n    = nxt[CNT_W-1:0];
      ovf_risk = (SUM_W'(cnt_q) + SUM_W'(ren_hits)) > CNT_MAX;
      ren_n    = grant ? 1'b0 : (ren_q | set_renamed);
      free_n   = grant ? 1'b0 : (free_q | (ren_n && (cnt_n == '0)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ren_q  <= 1'b0;
         free_q <= RESET_FREE;
      end else begin
         cnt_q  <= cnt_n;
         ren_q  <= ren_n;
         free_q <= free_n;
      end
   end

   a_r2_no_underflow : assert property (@(posedge clk) disable iff (!rst_n)
      down <= SUM_W'(cnt_q) + up);
   a_r6_count_fits : assert property (@(posedge clk) disable iff (!rst_n)
      nxt <= CNT_MAX || down > SUM_W'(cnt_q) + up);
   a_r7_grant_needs_zero : assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (free_q && cnt_q == '0));
   a_r7_grant_clears : assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> (!free_q && !ren_q));
   a_r4_freed_renamed : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(free_q) |-> (ren_q && cnt_q == '0));
endmodule

// File: rtl/reg_reclaimer.sv
module reg_reclaimer #(
   parameter int unsigned NUM_PREGS = rr_pkg::RR_NUM_PREGS,
   parameter int unsigned NUM_ARCH  = rr_pkg::RR_NUM_ARCH,
   parameter int unsigned CNT_W     = rr_pkg::RR_CNT_W,
   parameter int unsigned RN_SRCS   = rr_pkg::RR_PORTS_DEF,
   parameter int unsigned ISS_PORTS = rr_pkg::RR_PORTS_DEF,
   localparam int unsigned PW       = $clog2(NUM_PREGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ren_valid,
   input  logic [RN_SRCS-1:0]      ren_src_vld,
   input  logic [RN_SRCS*PW-1:0]   ren_src_tag,
   output logic                    ren_stall,
   input  logic                    ovw_valid,
   input  logic [PW-1:0]           ovw_tag,
   input  logic [ISS_PORTS-1:0]    iss_vld,
   input  logic [ISS_PORTS*PW-1:0] iss_tag,
   input  logic                    ckpt_new_valid,
   input  logic [NUM_PREGS-1:0]    ckpt_new_mask,
   input  logic                    ckpt_drop_valid,
   input  logic [NUM_PREGS-1:0]    ckpt_drop_mask,
   input  logic                    alloc_req,
   output logic                    alloc_gnt,
   output logic [PW-1:0]           alloc_tag,
   output logic [NUM_PREGS-1:0]    free_mask
);
   localparam int unsigned RH_W = $clog2(RN_SRCS + 1);
   localparam int unsigned IH_W = $clog2(ISS_PORTS + 1);

   if (NUM_PREGS < 2 || (1 << PW) != NUM_PREGS) begin : g_bad_pregs
      $error("reg_reclaimer: NUM_PREGS must be a power of two >= 2");
   end
   if (NUM_ARCH >= NUM_PREGS) begin : g_bad_arch
      $error("reg_reclaimer: NUM_ARCH must be below NUM_PREGS");
   end
   if (CNT_W < 2 || RN_SRCS < 1 || ISS_PORTS < 1) begin : g_bad_ports
      $error("reg_reclaimer: CNT_W, RN_SRCS or ISS_PORTS out of range");
   end

   logic [NUM_PREGS-1:0] ovf_vec, pick_oh, grant_vec;
   logic                 any_free, ren_go;

   assign ren_stall = ren_valid && (|ovf_vec);
   assign ren_go    = ren_valid && !ren_stall;
   assign alloc_gnt = alloc_req && any_free;
   assign grant_vec = alloc_gnt ? pick_oh : '0;

   for (genvar p = 0; p < int'(NUM_PREGS); p++) begin : g_slot
      logic [RH_W-1:0] rh;
      logic [IH_W-1:0] ih;
      logic            set_ren;

      rr_hit_count #(.PW(PW), .N(RN_SRCS), .IDX(p), .OUT_W(RH_W)) u_ren_hits (
         .vld(ren_src_vld), .tags(ren_src_tag), .hits(rh));
      rr_hit_count #(.PW(PW), .N(ISS_PORTS), .IDX(p), .OUT_W(IH_W)) u_iss_hits (
         .vld(iss_vld), .tags(iss_tag), .hits(ih));

      assign set_ren = ovw_valid && ren_go && (ovw_tag == PW'(p));

      rr_preg_slot #(
         .CNT_W(CNT_W), .RH_W(RH_W), .IH_W(IH_W),
         .RESET_FREE(p >= int'(NUM_ARCH))
      ) u_slot (
         .clk(clk), .rst_n(rst_n),
         .ren_hits(rh), .ren_go(ren_go),
         .ckpt_inc(ckpt_new_valid && ckpt_new_mask[p]),
         .iss_hits(ih),
         .ckpt_dec(ckpt_drop_valid && ckpt_drop_mask[p]),
         .set_renamed(set_ren), .grant(grant_vec[p]),
         .ovf_risk(ovf_vec[p]), .free_q(free_mask[p]));
   end

   rr_lowest_pick #(.N(NUM_PREGS), .IW(PW)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(free_mask),
      .onehot(pick_oh), .idx(alloc_tag), .any(any_free));

   a_r7_gnt_is_free : assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |-> free_mask[alloc_tag]);
   a_r7_gnt_leaves : assert property (@(posedge clk) disable iff (!rst_n)
      alloc_gnt |=> !free_mask[$past(alloc_tag)]);
   a_r6_stall_needs_rename : assert property (@(posedge clk) disable iff (!rst_n)
      ren_stall |-> ren_valid);
endmodule

// File: tb/reg_reclaimer_test.sv
module reg_reclaimer_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 32;

   typedef struct packed {
      logic        rv;
      logic        sv0; logic [4:0] s0;
      logic        sv1; logic [4:0] s1;
      logic        iv0; logic [4:0] i0;
      logic        iv1; logic [4:0] i1;
      logic        ov;  logic [4:0] ot;
      logic [31:0] cn;
      logic [31:0] cr;
      logic [4:0]  chk;
      logic        exp;
      logic [3:0]  rq;
   } step_t;

   localparam int NSTEP = 14;
   localparam step_t TBL [0:NSTEP-1] = '{
      '{1'b1, 1'b1, 5'd3, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 32'h0, 5'd3, 1'b0, 4'd5}, // R5 two sources on p3
      '{1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd3, 32'h0, 32'h0, 5'd3, 1'b0, 4'd9}, // R9 renamed, count 2
      '{1'b1, 1'b1, 5'd3, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 32'h0, 5'd3, 1'b0, 4'd5}, // R5 +1 -1 cancel
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd3, 1'b1, 5'd3, 1'b0, 5'd0, 32'h0, 32'h0, 5'd3, 1'b1, 4'd2}, // R2 last reads free p3
      '{1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd4, 32'h0, 32'h0, 5'd4, 1'b1, 4'd4}, // R4 zero count renamed
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'hA0, 32'h0, 5'd5, 1'b0, 4'd3}, // R3 create p5,p7
      '{1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 32'h0, 32'h0, 5'd5, 1'b0, 4'd3}, // R3 held by checkpoint
      '{1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd7, 32'h0, 32'h0, 5'd7, 1'b0, 4'd3}, // R3 held by checkpoint
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 32'h20, 5'd5, 1'b1, 4'd3}, // R3 release p5
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 32'h80, 5'd7, 1'b1, 4'd3}, // R3 release p7
      '{1'b1, 1'b1, 5'd8, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd8, 32'h100, 32'h0, 5'd8, 1'b0, 4'd5}, // R5 rename+create
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd8, 1'b0, 5'd0, 32'h0, 32'h100, 5'd8, 1'b1, 4'd5}, // R5 issue+release
      '{1'b1, 1'b1, 5'd6, 1'b1, 5'd6, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'h0, 32'h0, 5'd6, 1'b0, 4'd9}, // R9 counted p6
      '{1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd6, 1'b1, 5'd6, 1'b0, 5'd0, 32'h0, 32'h0, 5'd6, 1'b0, 4'd9}  // R9 zero but not renamed
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ren_valid;
   logic [1:0]    ren_src_vld;
   logic [9:0]    ren_src_tag;
   logic          ren_stall;
   logic          ovw_valid;
   logic [4:0]    ovw_tag;
   logic [1:0]    iss_vld;
   logic [9:0]    iss_tag;
   logic          ckpt_new_valid, ckpt_drop_valid;
   logic [NP-1:0] ckpt_new_mask, ckpt_drop_mask;
   logic          alloc_req, alloc_gnt;
   logic [4:0]    alloc_tag;
   logic [NP-1:0] free_mask;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   reg_reclaimer uut (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_src_vld(ren_src_vld), .ren_src_tag(ren_src_tag),
      .ren_stall(ren_stall), .ovw_valid(ovw_valid), .ovw_tag(ovw_tag),
      .iss_vld(iss_vld), .iss_tag(iss_tag),
      .ckpt_new_valid(ckpt_new_valid), .ckpt_new_mask(ckpt_new_mask),
      .ckpt_drop_valid(ckpt_drop_valid), .ckpt_drop_mask(ckpt_drop_mask),
      .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_tag(alloc_tag),
      .free_mask(free_mask));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic idle();
      ren_valid = 0; ren_src_vld = 0; ren_src_tag = 0;
      ovw_valid = 0; ovw_tag = 0; iss_vld = 0; iss_tag = 0;
      ckpt_new_valid = 0; ckpt_new_mask = 0; ckpt_drop_valid = 0; ckpt_drop_mask = 0;
      alloc_req = 0;
   endtask

   task automatic edge_step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int ngr;
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 free_mask", free_mask, 32'hFFFF0000);
      check("R1 stall", {31'd0, ren_stall}, 32'd0);
      alloc_req = 1; #1;
      check("R1/R7 gnt", {31'd0, alloc_gnt}, 32'd1);
      check("R1/R7 tag", {27'd0, alloc_tag}, 32'd16);
      alloc_req = 0;

      for (int i = 0; i < NSTEP; i++) begin
         @(negedge clk);
         ren_valid = TBL[i].rv;
         ren_src_vld = {TBL[i].sv1, TBL[i].sv0};
         ren_src_tag = {TBL[i].s1, TBL[i].s0};
         iss_vld = {TBL[i].iv1, TBL[i].iv0};
         iss_tag = {TBL[i].i1, TBL[i].i0};
         ovw_valid = TBL[i].ov; ovw_tag = TBL[i].ot;
         ckpt_new_valid = |TBL[i].cn; ckpt_new_mask = TBL[i].cn;
         ckpt_drop_valid = |TBL[i].cr; ckpt_drop_mask = TBL[i].cr;
         #1;
         check($sformatf("R%0d stall step %0d", TBL[i].rq, i), {31'd0, ren_stall}, 32'd0);
         edge_step();
         check($sformatf("R%0d free step %0d", TBL[i].rq, i),
               {31'd0, free_mask[TBL[i].chk]}, {31'd0, TBL[i].exp});
         idle();
      end

      // R7 lowest-first allocation: 3,4,5,7,8
      foreach (TBL[k]) begin end
      begin
         int exp_tags [5] = '{3, 4, 5, 7, 8};
         for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            alloc_req = 1; #1;
            check("R7 gnt", {31'd0, alloc_gnt}, 32'd1);
            check("R7 lowest tag", {27'd0, alloc_tag}, exp_tags[j]);
            edge_step();
            check("R7 granted leaves", {31'd0, free_mask[exp_tags[j]]}, 32'd0);
            idle();
         end
      end

      // R8 release and grant in same cycle: p9 one ref, renamed
      @(negedge clk);
      ren_valid = 1; ren_src_vld = 2'b01; ren_src_tag = {5'd0, 5'd9};
      ovw_valid = 1; ovw_tag = 5'd9;
      edge_step(); idle();
      check("R9 p9 counted", {31'd0, free_mask[9]}, 32'd0);
      @(negedge clk);
      iss_vld = 2'b01; iss_tag = {5'd0, 5'd9}; alloc_req = 1; #1;
      check("R8 grant skips releasing reg", {27'd0, alloc_tag}, 32'd16);
      edge_step(); idle();
      check("R8 p9 freed", {31'd0, free_mask[9]}, 32'd1);
      @(negedge clk);
      alloc_req = 1; #1;
      check("R8 p9 granted next", {27'd0, alloc_tag}, 32'd9);
      edge_step(); idle();

      // R6 overflow on p10
      for (int j = 0; j < 15; j++) begin
         @(negedge clk);
         ren_valid = 1; ren_src_vld = 2'b01; ren_src_tag = {5'd0, 5'd10}; #1;
         if (j == 14) check("R6 no stall reaching 15", {31'd0, ren_stall}, 32'd0);
         edge_step(); idle();
      end
      @(negedge clk);
      ren_valid = 1; ren_src_vld = 2'b01; ren_src_tag = {5'd0, 5'd10};
      ovw_valid = 1; ovw_tag = 5'd11; #1;
      check("R6 stall at 15", {31'd0, ren_stall}, 32'd1);
      edge_step(); idle();
      check("R6 overwrite blocked", {31'd0, free_mask[11]}, 32'd0);
      for (int j = 0; j < 7; j++) begin
         @(negedge clk);
         iss_vld = 2'b11; iss_tag = {5'd10, 5'd10};
         if (j == 0) begin
            ren_valid = 1; ovw_valid = 1; ovw_tag = 5'd10;
         end
         edge_step(); idle();
      end
      check("R6 count 1 left", {31'd0, free_mask[10]}, 32'd0);
      @(negedge clk);
      iss_vld = 2'b01; iss_tag = {5'd0, 5'd10};
      edge_step(); idle();
      check("R6 count was 15", {31'd0, free_mask[10]}, 32'd1);

      // R7 exhaustion: p10 and 17..31 remain
      ngr = 0;
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         alloc_req = 1; #1;
         if (alloc_gnt) ngr++;
         edge_step(); idle();
      end
      check("R7 grants until empty", ngr, 32'd16);
      @(negedge clk);
      alloc_req = 1; #1;
      check("R7 no grant when empty", {31'd0, alloc_gnt}, 32'd0);
      idle();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule